// File: doc/BRIEF.md
# Priority-Match CAM Access Unit

This block keeps a small associative array of 64-bit entries, each tagged with a validity flag. A compare command presents a 64-bit key. In the next cycle the block reports whether any valid entry equals the key, whether more than one does, and the index of the winning entry. The winner is the valid, equal entry with the lowest index.

After a compare, the host can read or write the winning entry without knowing where it sits. An access command addresses one 32-bit half of that entry. A write merges the new data under a mask taken from a small bank of mask registers. A write also sets the entry's validity flag. A read returns the selected half and the entry's empty status through a registered data output with an output enable. That enable stays low whenever the last compare missed.

Two side ports set up the contents: a direct load port for entries and a load port for the mask registers. Both are used at initialisation and by test software.

Top module: `cam_pm_unit`

## Requirements
- R1: In the cycle after synchronous reset is released, `match_flag`, `multi_flag`, `dout_oe`, `dout_empty` and `dout` are all zero, and every entry is empty.
- R2: A compare (`cmp_en` high) considers only entries whose validity flag is set and requires equality on all 64 bits. In the following cycle, `match_flag` shows whether any such entry exists.
- R3: When several valid entries equal the key, `match_idx` reports the lowest index among them. It is registered in the cycle after the compare.
- R4: `multi_flag` is high after a compare exactly when two or more valid entries equal the key, and it is never high without `match_flag`.
- R5: `match_flag`, `multi_flag` and `match_idx` change only on a compare or a reset. Loads, reads, writes and idle cycles leave them unchanged.
- R6: An access is recognised only when `acc_en` is high and `acc_op[5:0]` equals 6'b000010. `wr_n` high makes the access a read. One cycle after a read with a live match, `dout_oe` is high and `dout` holds bits 31:0 of the matched entry (`half_hi`=0) or bits 63:32 (`half_hi`=1). `dout_empty` is 1 if that entry is empty.
- R7: After a read whose last compare missed, and in every cycle that is not the cycle after a read, `dout_oe` and `dout_empty` are low and `dout` is zero.
- R8: An access with `wr_n` low writes `din` into the selected half of the matched entry. It sets that entry's validity from `vld_n`: 0 means valid, 1 means empty.
- R9: The write mask index is `acc_op[8:6]`. Index 0 applies no mask. Any other index takes the selected half of that mask register, and only bits whose mask bit is 0 are changed.
- R10: A write access issued while `match_flag` is low leaves every entry, including its validity, unchanged.
- R11: An access strobe whose `acc_op[5:0]` differs from 6'b000010 neither reads nor writes.
- R12: Commands in one cycle are prioritised as load, then compare, then access. `ld_en` replaces entry `ld_idx` with `ld_data` and sets its validity from `ld_valid`. `mask_we` writes mask register `mask_sel` independently of the other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Direct entry load strobe |
| ld_idx | input | 4 | Entry index for load |
| ld_data | input | 64 | Entry contents for load |
| ld_valid | input | 1 | Validity given to the loaded entry |
| mask_we | input | 1 | Mask register write strobe |
| mask_sel | input | 3 | Mask register index to write |
| mask_data | input | 64 | Mask register contents |
| cmp_en | input | 1 | Compare command |
| cmp_key | input | 64 | Compare key |
| acc_en | input | 1 | Access-at-match strobe |
| acc_op | input | 9 | [8:6] mask index, [5:0] access code |
| wr_n | input | 1 | 0 write, 1 read |
| half_hi | input | 1 | 0 selects bits 31:0, 1 selects bits 63:32 |
| vld_n | input | 1 | Validity for written entry, 0 valid, 1 empty |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, zero when disabled |
| dout_oe | output | 1 | Read data output enable |
| dout_empty | output | 1 | Empty status of the read entry |
| match_flag | output | 1 | Last compare found a match |
| multi_flag | output | 1 | Last compare found several matches |
| match_idx | output | 4 | Index of the winning entry |

## Verification
The bench targets several corner cases. A key that equals an emptied entry must miss, or a design that ignores validity would report a false hit. Several equal entries must resolve to the lowest index, or a reversed priority encoder would return the highest. A read after a miss must keep the output disabled, and a write after a miss must leave the array intact; a design that leaked an old index would corrupt a stale entry. Masked writes in both halves, codes that differ by a single access-code bit, and a long mixed random sequence exercise the merge logic and check that reads and writes never move the stored match state.

// File: rtl/cam_pm_pkg.sv
package cam_pm_pkg;

    localparam int unsigned ENTRY_W = 64;
    localparam int unsigned HALF_W  = ENTRY_W / 2;
    localparam int unsigned CODE_W  = 6;
    localparam logic [CODE_W-1:0] CODE_AT_MATCH = 6'b000010;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_CMP,
        CMD_ACC
    } cmd_e;

    typedef struct packed {
        logic              go;
        logic              hi;
        logic              valid;
        logic [HALF_W-1:0] data;
        logic [HALF_W-1:0] keep;
    } half_wr_t;

    typedef struct packed {
        logic              oe;
        logic              empty;
        logic [HALF_W-1:0] data;
    } rd_out_t;

    function automatic cmd_e decode_cmd(input logic ld, input logic cmp,
                                        input logic acc,
                                        input logic [CODE_W-1:0] code);
        if (ld)
            return CMD_LOAD;
        if (cmp)
            return CMD_CMP;
        if (acc && code == CODE_AT_MATCH)
            return CMD_ACC;
        return CMD_IDLE;
    endfunction

    function automatic logic [HALF_W-1:0] pick_half(input logic [ENTRY_W-1:0] w,
                                                    input logic hi);
        return hi ? w[ENTRY_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

    function automatic logic [ENTRY_W-1:0] merge_half(input logic [ENTRY_W-1:0] old,
                                                      input logic [HALF_W-1:0] nd,
                                                      input logic [HALF_W-1:0] keep,
                                                      input logic hi);
        logic [HALF_W-1:0] cur;
        logic [HALF_W-1:0] nxt;
        cur = pick_half(old, hi);
        nxt = (cur & keep) | (nd & ~keep);
        return hi ? {nxt, old[HALF_W-1:0]} : {old[ENTRY_W-1:HALF_W], nxt};
    endfunction

endpackage

// File: rtl/cam_pm_masks.sv
module cam_pm_masks
    import cam_pm_pkg::*;
#(
    parameter int unsigned NMASK = 8,
    localparam int unsigned MSEL_W = $clog2(NMASK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [MSEL_W-1:0]  wsel,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [MSEL_W-1:0]  rsel,
    input  logic               rhi,
    output logic [HALF_W-1:0]  keep
);

    logic [NMASK-1:0][ENTRY_W-1:0] bank;

    assign bank[0] = '0;

    for (genvar m = 1; m < NMASK; m++) begin : g_mreg
        always_ff @(posedge clk) begin
            if (rst)
                bank[m] <= '0;
            else if (we && wsel == MSEL_W'(m))
                bank[m] <= wdata;
        end
    end

    assign keep = pick_half(bank[rsel], rhi);

endmodule

// File: rtl/cam_pm_array.sv
module cam_pm_array
    import cam_pm_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ld_go,
    input  logic [IDX_W-1:0]               ld_idx,
    input  logic [ENTRY_W-1:0]             ld_data,
    input  logic                           ld_valid,
    input  half_wr_t                       wr,
    input  logic [IDX_W-1:0]               wr_idx,
    output logic [DEPTH-1:0][ENTRY_W-1:0]  ent_data,
    output logic [DEPTH-1:0]               ent_valid
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic ld_me;
        logic wr_me;
        assign ld_me = ld_go && ld_idx == IDX_W'(e);
        assign wr_me = wr.go && wr_idx == IDX_W'(e);

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_data[e]  <= '0;
                ent_valid[e] <= 1'b0;
            end else if (ld_me) begin
                ent_data[e]  <= ld_data;
                ent_valid[e] <= ld_valid;
            end else if (wr_me) begin
                ent_data[e]  <= merge_half(ent_data[e], wr.data, wr.keep, wr.hi);
                ent_valid[e] <= wr.valid;
            end
        end
    end

    // R12
    ld_wr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(ld_go && wr.go));

endmodule

// File: rtl/cam_pm_match.sv
module cam_pm_match
    import cam_pm_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cmp_go,
    input  logic [ENTRY_W-1:0]             key,
    input  logic [DEPTH-1:0][ENTRY_W-1:0]  ent_data,
    input  logic [DEPTH-1:0]               ent_valid,
    output logic                           match_flag,
    output logic                           multi_flag,
    output logic [IDX_W-1:0]               match_idx
);

    logic [DEPTH-1:0] hit;
    logic [IDX_W-1:0] winner;
    logic             any_hit;
    logic             many_hit;

    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
        assign hit[e] = ent_valid[e] && (ent_data[e] == key);
    end

    always_comb begin
        winner = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i])
                winner = IDX_W'(i);
        end
    end

    assign any_hit  = |hit;
    assign many_hit = (hit & (hit - 1'b1)) != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_flag <= 1'b0;
            multi_flag <= 1'b0;
            match_idx  <= '0;
        end else if (cmp_go) begin
            match_flag <= any_hit;
            multi_flag <= many_hit;
            match_idx  <= winner;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!match_flag && !multi_flag));

    // R4
    multi_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        multi_flag |-> match_flag);

    // R5
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cmp_go) && !$past(rst)) |->
        ($stable(match_flag) && $stable(multi_flag) && $stable(match_idx)));

endmodule

// File: rtl/cam_pm_unit.sv
module cam_pm_unit
    import cam_pm_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned NMASK = 8,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned MSEL_W = $clog2(NMASK),
    localparam int unsigned OP_W   = MSEL_W + CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_en,
    input  logic [IDX_W-1:0]    ld_idx,
    input  logic [ENTRY_W-1:0]  ld_data,
    input  logic                ld_valid,
    input  logic                mask_we,
    input  logic [MSEL_W-1:0]   mask_sel,
    input  logic [ENTRY_W-1:0]  mask_data,
    input  logic                cmp_en,
    input  logic [ENTRY_W-1:0]  cmp_key,
    input  logic                acc_en,
    input  logic [OP_W-1:0]     acc_op,
    input  logic                wr_n,
    input  logic                half_hi,
    input  logic                vld_n,
    input  logic [HALF_W-1:0]   din,
    output logic [HALF_W-1:0]   dout,
    output logic                dout_oe,
    output logic                dout_empty,
    output logic                match_flag,
    output logic                multi_flag,
    output logic [IDX_W-1:0]    match_idx
);

    cmd_e                          cmd;
    logic                          rd_go;
    logic [HALF_W-1:0]             keep;
    half_wr_t                      wr;
    rd_out_t                       rd_q;
    logic [DEPTH-1:0][ENTRY_W-1:0] ent_data;
    logic [DEPTH-1:0]              ent_valid;
    logic [ENTRY_W-1:0]            sel_entry;

    assign cmd   = decode_cmd(ld_en, cmp_en, acc_en, acc_op[CODE_W-1:0]);
    assign rd_go = (cmd == CMD_ACC) && wr_n;

    cam_pm_masks #(.NMASK(NMASK)) u_masks (
        .clk   (clk),
        .rst   (rst),
        .we    (mask_we),
        .wsel  (mask_sel),
        .wdata (mask_data),
        .rsel  (acc_op[OP_W-1:CODE_W]),
        .rhi   (half_hi),
        .keep  (keep)
    );

    always_comb begin
        wr.go    = (cmd == CMD_ACC) && !wr_n && match_flag;
        wr.hi    = half_hi;
        wr.valid = !vld_n;
        wr.data  = din;
        wr.keep  = keep;
    end

    cam_pm_array #(.DEPTH(DEPTH)) u_array (
        .clk       (clk),
        .rst       (rst),
        .ld_go     (cmd == CMD_LOAD),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .ld_valid  (ld_valid),
        .wr        (wr),
        .wr_idx    (match_idx),
        .ent_data  (ent_data),
        .ent_valid (ent_valid)
    );

    cam_pm_match #(.DEPTH(DEPTH)) u_match (
        .clk        (clk),
        .rst        (rst),
        .cmp_go     (cmd == CMD_CMP),
        .key        (cmp_key),
        .ent_data   (ent_data),
        .ent_valid  (ent_valid),
        .match_flag (match_flag),
        .multi_flag (multi_flag),
        .match_idx  (match_idx)
    );

    assign sel_entry = ent_data[match_idx];

    always_ff @(posedge clk) begin
        if (rst || !(rd_go && match_flag)) begin
            rd_q <= '0;
        end else begin
            rd_q.oe    <= 1'b1;
            rd_q.empty <= !ent_valid[match_idx];
            rd_q.data  <= pick_half(sel_entry, half_hi);
        end
    end

    assign dout       = rd_q.data;
    assign dout_oe    = rd_q.oe;
    assign dout_empty = rd_q.empty;

    // R7
    oe_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> match_flag);

    // R7
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> (dout == '0 && !dout_empty));

    // R6
    oe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> $past(acc_en && wr_n));

endmodule

// File: tb/tb_cam_pm_unit.sv
module tb_cam_pm_unit;

    localparam int DEPTH = 16;
    localparam int NMASK = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en, ld_valid, mask_we, cmp_en, acc_en, wr_n, half_hi, vld_n;
    logic [3:0]  ld_idx;
    logic [63:0] ld_data, mask_data, cmp_key;
    logic [2:0]  mask_sel;
    logic [8:0]  acc_op;
    logic [31:0] din;
    logic [31:0] dout;
    logic        dout_oe, dout_empty, match_flag, multi_flag;
    logic [3:0]  match_idx;

    int total = 0;
    int bad   = 0;
    string tag = "R1";
    bit finished = 0;

    always #10 clk = ~clk;

    cam_pm_unit #(.DEPTH(DEPTH), .NMASK(NMASK)) dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .ld_valid(ld_valid), .mask_we(mask_we), .mask_sel(mask_sel),
        .mask_data(mask_data), .cmp_en(cmp_en), .cmp_key(cmp_key),
        .acc_en(acc_en), .acc_op(acc_op), .wr_n(wr_n), .half_hi(half_hi),
        .vld_n(vld_n), .din(din), .dout(dout), .dout_oe(dout_oe),
        .dout_empty(dout_empty), .match_flag(match_flag),
        .multi_flag(multi_flag), .match_idx(match_idx)
    );

    // behavioural reference model
    logic [63:0] m_mem [DEPTH];
    bit          m_val [DEPTH];
    logic [63:0] m_msk [NMASK];
    bit          m_hit, m_multi;
    int          m_idx;
    logic [31:0] e_dout;
    bit          e_oe, e_empty;

    always @(posedge clk) begin
        bit          nh;
        int          cnt, first;
        logic [31:0] keep, cur, nxt;
        e_oe = 0; e_empty = 0; e_dout = '0;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_val[i] = 0; end
            for (int i = 0; i < NMASK; i++) m_msk[i] = '0;
            m_hit = 0; m_multi = 0; m_idx = 0;
        end else begin
            if (ld_en) begin
                m_mem[ld_idx] = ld_data;
                m_val[ld_idx] = ld_valid;
            end else if (cmp_en) begin
                cnt = 0; first = 0;
                for (int i = DEPTH - 1; i >= 0; i--)
                    if (m_val[i] && m_mem[i] == cmp_key) begin cnt++; first = i; end
                m_hit = cnt > 0; m_multi = cnt > 1; m_idx = first;
            end else if (acc_en && acc_op[5:0] == 6'b000010) begin
                if (wr_n) begin
                    if (m_hit) begin
                        e_oe = 1;
                        e_empty = !m_val[m_idx];
                        e_dout = half_hi ? m_mem[m_idx][63:32] : m_mem[m_idx][31:0];
                    end
                end else if (m_hit) begin
                    keep = (acc_op[8:6] == 0) ? 32'h0 :
                           (half_hi ? m_msk[acc_op[8:6]][63:32] : m_msk[acc_op[8:6]][31:0]);
                    cur = half_hi ? m_mem[m_idx][63:32] : m_mem[m_idx][31:0];
                    nxt = (cur & keep) | (din & ~keep);
                    if (half_hi) m_mem[m_idx][63:32] = nxt;
                    else         m_mem[m_idx][31:0]  = nxt;
                    m_val[m_idx] = !vld_n;
                end
            end
            if (mask_we) m_msk[mask_sel] = mask_data;
        end
        nh = 0;
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("match_flag", 64'(match_flag), 64'(m_hit));
            chk("multi_flag", 64'(multi_flag), 64'(m_multi));
            chk("match_idx",  64'(match_idx),  64'(m_idx));
            chk("dout_oe",    64'(dout_oe),    64'(e_oe));
            chk("dout_empty", 64'(dout_empty), 64'(e_empty));
            chk("dout",       64'(dout),       64'(e_dout));
        end
    end

    task automatic idle();
        ld_en = 0; mask_we = 0; cmp_en = 0; acc_en = 0;
        ld_valid = 0; wr_n = 1; half_hi = 0; vld_n = 0;
        ld_idx = '0; ld_data = '0; mask_sel = '0; mask_data = '0;
        cmp_key = '0; acc_op = '0; din = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load(input int idx, input logic [63:0] d, input bit v);
        idle(); ld_en = 1; ld_idx = 4'(idx); ld_data = d; ld_valid = v; step(); idle();
    endtask

    task automatic setmask(input int s, input logic [63:0] d);
        idle(); mask_we = 1; mask_sel = 3'(s); mask_data = d; step(); idle();
    endtask

    task automatic compare(input logic [63:0] k);
        idle(); cmp_en = 1; cmp_key = k; step(); idle();
    endtask

    task automatic rd(input bit hi, input logic [5:0] code);
        idle(); acc_en = 1; acc_op = {3'd0, code}; wr_n = 1; half_hi = hi; step();
        idle(); step();
    endtask

    task automatic wr(input bit hi, input int ms, input logic [31:0] d, input bit vn,
                      input logic [5:0] code);
        idle(); acc_en = 1; acc_op = {3'(ms), code}; wr_n = 0; half_hi = hi;
        din = d; vld_n = vn; step(); idle();
    endtask

    localparam logic [63:0] KA = 64'hA5A5_0001_DEAD_BEEF;
    localparam logic [63:0] KB = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] KD = 64'h0F0F_0F0F_F0F0_F0F0;

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1";
        step();
        chk("reset oe", 64'(dout_oe), 64'd0);
        chk("reset match", 64'(match_flag), 64'd0);
        compare(64'd0);
        step();
        chk("reset empty array miss", 64'(match_flag), 64'd0);

        tag = "R7";
        rd(0, 6'b000010);
        chk("miss read oe", 64'(dout_oe), 64'd0);

        tag = "R12";
        load(3, KA, 1); load(7, KA, 1); load(12, KA, 1);
        load(5, KB, 1); load(9, KD, 0);
        setmask(1, 64'hFFFF_0000_0000_FFFF);
        setmask(2, 64'h00FF_00FF_FF00_FF00);
        idle(); ld_en = 1; cmp_en = 1; ld_idx = 4'd2; ld_data = 64'h55; ld_valid = 1;
        cmp_key = KB; step(); idle(); step();

        tag = "R3";
        compare(KA); step();
        chk("lowest index", 64'(match_idx), 64'd3);
        tag = "R4";
        chk("multi", 64'(multi_flag), 64'd1);
        tag = "R6";
        rd(0, 6'b000010);
        rd(1, 6'b000010);

        tag = "R2";
        compare(KD); step();
        chk("invalid entry ignored", 64'(match_flag), 64'd0);
        compare(KD ^ 64'h1_0000_0000);
        tag = "R7";
        rd(1, 6'b000010);
        tag = "R10";
        wr(0, 0, 32'hFFFF_FFFF, 0, 6'b000010);
        compare(KB); step();
        chk("single", 64'(multi_flag), 64'd0);
        rd(0, 6'b000010);

        tag = "R8";
        wr(1, 0, 32'hCAFE_F00D, 0, 6'b000010);
        rd(1, 6'b000010);
        tag = "R9";
        wr(0, 1, 32'h0000_0000, 0, 6'b000010);
        rd(0, 6'b000010);
        wr(1, 2, 32'hFFFF_FFFF, 0, 6'b000010);
        rd(1, 6'b000010);
        tag = "R5";
        repeat (3) step();
        rd(0, 6'b000010);
        tag = "R8";
        wr(0, 0, 32'h1111_2222, 1, 6'b000010);
        rd(0, 6'b000010);
        chk("empty flag", 64'(dout_empty), 64'd0);
        tag = "R11";
        wr(0, 0, 32'h3333_4444, 0, 6'b000110);
        rd(0, 6'b000011);
        rd(0, 6'b000010);

        tag = "R3";
        for (int n = 0; n < 600; n++) begin
            int sel;
            idle();
            sel = $urandom_range(0, 9);
            case (sel)
                0: begin ld_en = 1; ld_idx = 4'($urandom_range(0, 15));
                         ld_data = {62'd0, 2'($urandom_range(0, 3))};
                         ld_valid = 1'($urandom_range(0, 1)); end
                1: begin mask_we = 1; mask_sel = 3'($urandom_range(0, 7));
                         mask_data = {$urandom, $urandom}; end
                2, 3: begin cmp_en = 1; cmp_key = {62'd0, 2'($urandom_range(0, 3))}; end
                4, 5, 6, 7: begin acc_en = 1;
                         acc_op = {3'($urandom_range(0, 7)),
                                   ($urandom_range(0, 4) == 0) ? 6'b100010 : 6'b000010};
                         wr_n = 1'($urandom_range(0, 1)); half_hi = 1'($urandom_range(0, 1));
                         vld_n = ($urandom_range(0, 5) == 0); din = $urandom;
                         cmp_en = ($urandom_range(0, 7) == 0); end
                default: ;
            endcase
            step();
        end
        idle(); step();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule